// File: doc/BRIEF.md
# Security-Aware Exception Entry Controller

This block works out every register write a processor core makes when it takes one exception. The core has already picked the exception, so this block does no arbitration. The block receives the chosen exception class, the current status word and a reference PC. It also receives the security configuration bits, three vector base addresses, a high-vector enable and an interrupt handler address from an external interrupt controller. From these it produces the new status word, the value saved into the target mode's saved status, the link value, the new PC and a request to clear the non-secure bit.

The security configuration decides how IRQ, FIQ and external aborts are routed. Each of them goes either to its normal handling mode or to the monitor mode. The world the core is in decides which vector base is used. It also decides how the FIQ-disable and imprecise-abort-disable bits change, and which control register supplies the endianness bit. The results appear as a single-cycle update pulse one clock after the request.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Exception class codes are 0 reset, 1 undefined, 2 supervisor call, 3 monitor call, 4 internal fetch abort, 5 external fetch abort, 6 internal data abort, 7 external data abort, 8 IRQ and 9 FIQ. Under normal routing, `upd_psr[4:0]` is set as follows: reset and supervisor call 10011, undefined 11011, all aborts 10111, IRQ 10010, FIQ 10001.
- R2: The new PC is the world base plus an offset. The offsets are 0x4 for undefined, 0x8 for calls, 0xC for fetch aborts, 0x10 for data aborts, 0x18 for IRQ and 0x1C for FIQ. The world base is `s_base` in the secure world and `ns_base` in the non-secure world. When `hivec_en` is 1, the world base is 0xFFFF0000 instead.
- R3: `sec_cfg[1]` routes IRQ to monitor mode, `sec_cfg[2]` routes FIQ and `sec_cfg[3]` routes both external abort classes. A routed exception enters mode 10110 at `mon_base` plus its offset, whatever the value of `hivec_en`. It also sets bits 6, 7 and 8.
- R4: The link value is `cur_pc`+4 for undefined, calls, fetch aborts, IRQ and FIQ, and `cur_pc`+8 for data aborts. Here `cur_pc` is the address of the instruction concerned, or the next-to-execute address for an interrupt.
- R5: Every entry clears bits 5 and 24 and sets bit 7. Every entry except reset also writes the old status word to `upd_spsr` with `spsr_we`, and the link value with `lr_we`. Status bits that are not named in the requirements are carried over from `cur_psr`.
- R6: In the non-secure world (`sec_cfg[0]`=1) with normal routing, bit 8 is set for aborts, IRQ and FIQ only when `sec_cfg[5]` is 1, and is otherwise left unchanged. In the secure world it is always set for these classes. Bit 6 is set only for FIQ. Undefined and supervisor call leave bits 6 and 8 unchanged.
- R7: A monitor call made from user mode (10000) is handled as an undefined instruction. Made from any other mode, it enters mode 10110 at `mon_base`+0x8 and sets bits 6 and 8.
- R8: An IRQ under normal routing with `vic_en`=1 takes its PC from `irq_handler`. A routed IRQ ignores `vic_en`.
- R9: Bit 9 takes the value of `s_ee` when the destination is secure (secure world, monitor mode or reset), and `ns_ee` otherwise.
- R10: The reset class enters mode 10011 and sets bits 6, 7 and 8. Its PC is 0, or 0xFFFF0000 when `hivec_en` is 1. It makes no saved-status or link write and asserts `ns_clr`.
- R11: An exception taken while the current mode is monitor (10110) is handled as secure, even when `sec_cfg[0]` is 1, and asserts `ns_clr`.
- R12: `upd_valid` and the write strobes pulse for exactly one cycle, in the clock after a cycle with `exc_valid` high. They stay low otherwise, and all outputs are zero in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_valid | input | 1 | An exception is to be taken this cycle |
| exc_class | input | 4 | Selected exception class |
| cur_psr | input | 32 | Current status word |
| cur_pc | input | 32 | Reference instruction address |
| sec_cfg | input | 6 | [0] non-secure, [1] IRQ route, [2] FIQ route, [3] ext abort route, [4] unused, [5] abort-mask write |
| hivec_en | input | 1 | High vectors enabled |
| vic_en | input | 1 | Use interrupt-controller handler address for IRQ |
| irq_handler | input | 32 | Handler address from interrupt controller |
| s_base | input | 32 | Secure vector base |
| ns_base | input | 32 | Non-secure vector base |
| mon_base | input | 32 | Monitor vector base |
| s_ee | input | 1 | Secure control register endianness bit |
| ns_ee | input | 1 | Non-secure control register endianness bit |
| upd_valid | output | 1 | Update pulse |
| upd_psr | output | 32 | New status word |
| upd_spsr | output | 32 | Value for the target mode's saved status |
| spsr_we | output | 1 | Saved status write strobe |
| upd_lr | output | 32 | Link value |
| lr_we | output | 1 | Link write strobe |
| upd_pc | output | 32 | New PC |
| ns_clr | output | 1 | Clear the non-secure bit |

## Verification
The bench targets these corner cases:
- The bit-8 rule in the non-secure world, tested with the abort-mask write bit both clear and set. A design that sets the bit unconditionally would mask imprecise aborts that software expects to remain open.
- Monitor routing with high vectors on. A design that also replaced the monitor base would vector to 0xFFFF00xx.
- A vectored IRQ with and without routing.
- A monitor call from user mode and from a privileged mode. Getting this wrong either lets user code into monitor mode or traps a legitimate call.
- Exceptions taken in monitor mode while the non-secure bit is set. A design that misses this picks the non-secure base and endianness.
- Reset, which must not write saved status or link.

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int          W      = 32,
  parameter logic [31:0] HI_VEC = 32'hFFFF_0000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         exc_valid,
  input  logic [3:0]   exc_class,
  input  logic [W-1:0] cur_psr,
  input  logic [W-1:0] cur_pc,
  input  logic [5:0]   sec_cfg,
  input  logic         hivec_en,
  input  logic         vic_en,
  input  logic [W-1:0] irq_handler,
  input  logic [W-1:0] s_base,
  input  logic [W-1:0] ns_base,
  input  logic [W-1:0] mon_base,
  input  logic         s_ee,
  input  logic         ns_ee,
  output logic         upd_valid,
  output logic [W-1:0] upd_psr,
  output logic [W-1:0] upd_spsr,
  output logic         spsr_we,
  output logic [W-1:0] upd_lr,
  output logic         lr_we,
  output logic [W-1:0] upd_pc,
  output logic         ns_clr
);
  localparam logic [3:0] C_RST = 4'd0, C_UND = 4'd1, C_SVC = 4'd2, C_SMC = 4'd3,
                         C_IPA = 4'd4, C_EPA = 4'd5, C_IDA = 4'd6, C_EDA = 4'd7,
                         C_IRQ = 4'd8, C_FIQ = 4'd9;
  localparam logic [4:0] M_USR = 5'b10000, M_SVC = 5'b10011, M_UND = 5'b11011,
                         M_ABT = 5'b10111, M_IRQ = 5'b10010, M_FIQ = 5'b10001,
                         M_MON = 5'b10110;

  logic in_mon, secure, is_rst, is_ext, smc_user, to_mon, is_irq;
  logic f_set, a_set, dest_sec;
  logic [4:0]   mode;
  logic [W-1:0] offs, ladd, wbase, pc_n, psr_n;
  logic         abort_int;

  assign in_mon   = cur_psr[4:0] == M_MON;
  assign secure   = !sec_cfg[0] || in_mon;
  assign is_rst   = exc_class == C_RST;
  assign is_irq   = exc_class == C_IRQ;
  assign is_ext   = (exc_class == C_EPA) || (exc_class == C_EDA);
  assign smc_user = (exc_class == C_SMC) && (cur_psr[4:0] == M_USR);
  assign to_mon   = (is_irq && sec_cfg[1]) || ((exc_class == C_FIQ) && sec_cfg[2]) ||
                    (is_ext && sec_cfg[3]) || ((exc_class == C_SMC) && !smc_user);

  always_comb begin
    mode = M_SVC; offs = '0; ladd = W'(4); abort_int = 1'b0;
    case (exc_class)
      C_RST: begin mode = M_SVC; offs = '0; end
      C_UND: begin mode = M_UND; offs = W'(4); end
      C_SVC: begin mode = M_SVC; offs = W'(8); end
      C_SMC: begin mode = smc_user ? M_UND : M_MON; offs = smc_user ? W'(4) : W'(8); end
      C_IPA, C_EPA: begin mode = M_ABT; offs = W'(12); abort_int = 1'b1; end
      C_IDA, C_EDA: begin mode = M_ABT; offs = W'(16); ladd = W'(8); abort_int = 1'b1; end
      C_IRQ: begin mode = M_IRQ; offs = W'(24); abort_int = 1'b1; end
      C_FIQ: begin mode = M_FIQ; offs = W'(28); abort_int = 1'b1; end
      default: begin mode = M_UND; offs = W'(4); end
    endcase
    if (to_mon) mode = M_MON;
  end

  assign f_set    = is_rst || to_mon || (exc_class == C_FIQ);
  assign a_set    = is_rst || to_mon || (abort_int && (secure || sec_cfg[5]));
  assign dest_sec = is_rst || to_mon || secure;
  assign wbase    = hivec_en ? HI_VEC : (secure ? s_base : ns_base);

  always_comb begin
    if (is_rst)                           pc_n = hivec_en ? HI_VEC : '0;
    else if (to_mon)                      pc_n = mon_base + offs;
    else if (is_irq && vic_en)            pc_n = irq_handler;
    else                                  pc_n = wbase + offs;
  end

  always_comb begin
    psr_n       = cur_psr;
    psr_n[4:0]  = mode;
    psr_n[5]    = 1'b0;
    psr_n[7]    = 1'b1;
    psr_n[24]   = 1'b0;
    psr_n[9]    = dest_sec ? s_ee : ns_ee;
    if (f_set) psr_n[6] = 1'b1;
    if (a_set) psr_n[8] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_valid <= 1'b0; spsr_we <= 1'b0; lr_we <= 1'b0; ns_clr <= 1'b0;
      upd_psr <= '0; upd_spsr <= '0; upd_lr <= '0; upd_pc <= '0;
    end else begin
      upd_valid <= exc_valid;
      spsr_we   <= exc_valid && !is_rst;
      lr_we     <= exc_valid && !is_rst;
      ns_clr    <= exc_valid && (is_rst || in_mon);
      if (exc_valid) begin
        upd_psr  <= psr_n;
        upd_spsr <= cur_psr;
        upd_lr   <= cur_pc + ladd;
        upd_pc   <= pc_n;
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exc_valid,
  input logic [31:0] cur_psr,
  input logic        upd_valid,
  input logic [31:0] upd_psr,
  input logic [31:0] upd_spsr,
  input logic        spsr_we,
  input logic        lr_we,
  input logic        ns_clr
);
  p_pulse_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> $past(exc_valid));
  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |=> !upd_valid);
  p_entry_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (upd_psr[7] && !upd_psr[5] && !upd_psr[24]));
  p_saved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    spsr_we |-> (upd_valid && lr_we && upd_spsr == $past(cur_psr)));
  p_mon_masks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_psr[4:0] == 5'b10110) |-> (upd_psr[6] && upd_psr[8]));
  p_nsclr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ns_clr |-> upd_valid);
endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
  .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .cur_psr(cur_psr),
  .upd_valid(upd_valid), .upd_psr(upd_psr), .upd_spsr(upd_spsr),
  .spsr_we(spsr_we), .lr_we(lr_we), .ns_clr(ns_clr)
);

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;
  logic clk = 0, rst_n = 0;
  logic exc_valid = 0;
  logic [3:0] exc_class = 0;
  logic [31:0] cur_psr = 0, cur_pc = 0, irq_handler = 32'h4444_0000;
  logic [5:0] sec_cfg = 0;
  logic hivec_en = 0, vic_en = 0, s_ee = 0, ns_ee = 1;
  logic [31:0] s_base = 32'h2000_0000, ns_base = 32'h1000_0000, mon_base = 32'h3000_0000;
  logic upd_valid, spsr_we, lr_we, ns_clr;
  logic [31:0] upd_psr, upd_spsr, upd_lr, upd_pc;
  int n_run = 0, n_fail = 0;

  localparam logic [31:0] USR = 32'h0100_0030, SVC = 32'h0100_0033, MON = 32'h0100_0036;

  always #10 clk = ~clk;

  exc_entry_ctrl u0 (.*);

  function automatic logic [31:0] xp(input logic [31:0] c, input logic [4:0] m,
                                     input logic f, input logic a, input logic ee);
    logic [31:0] r = c;
    r[4:0] = m; r[5] = 0; r[24] = 0; r[7] = 1; r[9] = ee;
    if (f) r[6] = 1;
    if (a) r[8] = 1;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic go(input logic [3:0] c, input logic [31:0] psr, input logic [31:0] pc);
    @(negedge clk);
    exc_class = c; cur_psr = psr; cur_pc = pc; exc_valid = 1;
    @(negedge clk);
    exc_valid = 0;
  endtask

  task automatic t_reset_state;
    chk("R12 reset valid", upd_valid, 0);
    chk("R12 reset pc", upd_pc, 0);
    chk("R12 reset psr", upd_psr, 0);
  endtask

  task automatic t_ns_undef;
    sec_cfg = 6'b000001; hivec_en = 0;
    go(1, USR, 32'h8000);
    chk("R12 pulse", upd_valid, 1);
    chk("R1 R6 R9 undef psr", upd_psr, xp(USR, 5'b11011, 0, 0, 1));
    chk("R2 undef pc", upd_pc, 32'h1000_0004);
    chk("R4 undef lr", upd_lr, 32'h8004);
    chk("R5 spsr", upd_spsr, USR);
    chk("R5 strobes", {spsr_we, lr_we, ns_clr}, 3'b110);
    @(negedge clk);
    chk("R12 single pulse", {upd_valid, spsr_we, lr_we}, 0);
  endtask

  task automatic t_ns_svc;
    sec_cfg = 6'b000001;
    go(2, USR, 32'h100);
    chk("R1 svc psr", upd_psr, xp(USR, 5'b10011, 0, 0, 1));
    chk("R2 svc pc", upd_pc, 32'h1000_0008);
  endtask

  task automatic t_ns_dabt_aw;
    sec_cfg = 6'b000001;
    go(6, USR, 32'h9000);
    chk("R6 A unchanged", upd_psr, xp(USR, 5'b10111, 0, 0, 1));
    chk("R4 dabt lr", upd_lr, 32'h9008);
    chk("R2 dabt pc", upd_pc, 32'h1000_0010);
    sec_cfg = 6'b100001;
    go(6, USR, 32'h9000);
    chk("R6 A set by cfg5", upd_psr, xp(USR, 5'b10111, 0, 1, 1));
  endtask

  task automatic t_route_eda;
    sec_cfg = 6'b001001;
    go(7, USR, 32'hA000);
    chk("R3 routed eda psr", upd_psr, xp(USR, 5'b10110, 1, 1, 0));
    chk("R3 routed eda pc", upd_pc, 32'h3000_0010);
    chk("R4 routed eda lr", upd_lr, 32'hA008);
  endtask

  task automatic t_sec_epa;
    sec_cfg = 6'b000000; hivec_en = 0;
    go(5, USR, 32'hB000);
    chk("R6 R9 secure epa psr", upd_psr, xp(USR, 5'b10111, 0, 1, 0));
    chk("R2 secure base", upd_pc, 32'h2000_000C);
    chk("R4 fetch lr", upd_lr, 32'hB004);
    hivec_en = 1;
    go(5, USR, 32'hB000);
    chk("R2 hivec replaces base", upd_pc, 32'hFFFF_000C);
    hivec_en = 0;
  endtask

  task automatic t_irq;
    sec_cfg = 6'b000011; hivec_en = 1; vic_en = 1;
    go(8, USR, 32'hC000);
    chk("R3 R8 routed irq pc keeps mon base", upd_pc, 32'h3000_0018);
    chk("R3 routed irq psr", upd_psr, xp(USR, 5'b10110, 1, 1, 0));
    sec_cfg = 6'b000001; hivec_en = 0;
    go(8, USR, 32'hC000);
    chk("R8 vectored irq pc", upd_pc, 32'h4444_0000);
    chk("R1 irq psr", upd_psr, xp(USR, 5'b10010, 0, 0, 1));
    chk("R4 irq lr", upd_lr, 32'hC004);
    vic_en = 0;
    go(8, USR, 32'hC000);
    chk("R2 irq table pc", upd_pc, 32'h1000_0018);
  endtask

  task automatic t_fiq;
    sec_cfg = 6'b000001;
    go(9, USR, 32'hD000);
    chk("R1 R6 fiq psr", upd_psr, xp(USR, 5'b10001, 1, 0, 1));
    chk("R2 fiq pc", upd_pc, 32'h1000_001C);
    chk("R4 fiq lr", upd_lr, 32'hD004);
  endtask

  task automatic t_smc;
    sec_cfg = 6'b000001;
    go(3, USR, 32'hE000);
    chk("R7 user smc psr", upd_psr, xp(USR, 5'b11011, 0, 0, 1));
    chk("R7 user smc pc", upd_pc, 32'h1000_0004);
    go(3, SVC, 32'hE000);
    chk("R7 smc psr", upd_psr, xp(SVC, 5'b10110, 1, 1, 0));
    chk("R7 smc pc", upd_pc, 32'h3000_0008);
    chk("R4 smc lr", upd_lr, 32'hE004);
  endtask

  task automatic t_in_mon;
    sec_cfg = 6'b000001;
    go(1, MON, 32'hF000);
    chk("R11 secure base from monitor", upd_pc, 32'h2000_0004);
    chk("R11 R9 ee secure", upd_psr, xp(MON, 5'b11011, 0, 0, 0));
    chk("R11 ns_clr", ns_clr, 1);
  endtask

  task automatic t_rst_class;
    sec_cfg = 6'b000001; hivec_en = 0;
    go(0, USR, 32'h1234);
    chk("R10 reset psr", upd_psr, xp(USR, 5'b10011, 1, 1, 0));
    chk("R10 reset pc", upd_pc, 0);
    chk("R10 no writes", {spsr_we, lr_we, ns_clr}, 3'b001);
    hivec_en = 1;
    go(0, USR, 32'h1234);
    chk("R10 reset hivec pc", upd_pc, 32'hFFFF_0000);
    hivec_en = 0;
  endtask

  initial begin
    fork
      begin
        #5; t_reset_state();
        #30 rst_n = 1;
        t_ns_undef(); t_ns_svc(); t_ns_dabt_aw(); t_route_eda(); t_sec_epa();
        t_irq(); t_fiq(); t_smc(); t_in_mon(); t_rst_class();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog R12 act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule